// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This unit decides, on every clock, which of several hardware threads may place an instruction into a shared single-issue, in-order pipeline. Each thread has its own small state machine that records whether the thread is parked, ready, held in a post-issue shadow after a load or branch, or waiting for a cache fill. A rotating-priority picker chooses the first ready thread. It starts from the thread just after the one that issued most recently. When no thread is ready, the unit reports an idle slot.

The pipeline tells the unit, in the same cycle as the issue, whether the issued instruction is a load or a branch. The memory side reports misses and fill returns by thread number. Software-visible control is limited to one enable bit per thread. A thread whose bit is low is parked.

Per-thread states: `TS_PARKED` (enable low, nothing outstanding), `TS_READY` (may issue), `TS_SHADOW` (countdown after a load or branch is non-zero), `TS_MISS` (miss outstanding). The next state is chosen with this priority: a pending miss leads to `TS_MISS`; otherwise a non-zero countdown leads to `TS_SHADOW`; otherwise the registered enable picks `TS_READY` or `TS_PARKED`. Transitions:
- a miss report moves any state to `TS_MISS`.
- a fill return leaves `TS_MISS` for `TS_SHADOW`, `TS_READY` or `TS_PARKED`.
- a long-op issue moves `TS_READY` to `TS_SHADOW`.
- an expired countdown moves `TS_SHADOW` to `TS_READY` or `TS_PARKED`.
- a change of enable moves between `TS_PARKED` and `TS_READY`.

Top module: `thread_select_top`

## Requirements
- R1: When `issue_valid` is 1, `issue_tid` is the first ready thread found by searching upward, with wrap-around, from the rotation pointer. The pointer equals the last issued thread number plus one, modulo 4.
- R2: If the thread that issued in the previous cycle is not the only ready thread, a different thread is issued in this cycle.
- R3: A `miss_req` with `miss_tid`=k in cycle t blocks thread k from cycle t+1 onward. A `fill_req` with `fill_tid`=k in cycle u makes k eligible again from cycle u+1, unless some other hold still applies.
- R4: If thread k issues in cycle t with `issue_long`=1, thread k does not issue in cycles t+1, t+2 and t+3. It may issue again from cycle t+4.
- R5: `issue_valid` is 0 only when no thread is ready. An idle cycle leaves the rotation pointer unchanged.
- R6: `thr_en` is registered. A thread whose registered enable bit is 0 is never selected.
- R7: After reset all threads are parked, all countdowns are zero, no miss is pending and the pointer is 0. When all four threads are enabled together, the first thread to issue is thread 0.
- R8: A miss report and a fill return for the same thread in the same cycle leave the miss pending.
- R9: A fill return for a thread with no pending miss has no effect on its selection.
- R10: A miss reported while a thread is in its shadow keeps the thread blocked after the shadow ends, until its fill returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | 4 | Per-thread enable; bit k low parks thread k |
| issue_long | input | 1 | The instruction issued this cycle is a load or a branch (qualified by issue_valid) |
| miss_req | input | 1 | Cache miss report pulse |
| miss_tid | input | 2 | Thread number for miss_req |
| fill_req | input | 1 | Fill return pulse |
| fill_tid | input | 2 | Thread number for fill_req |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | 2 | Number of the issuing thread |

## Verification
The bench goes after these corner cases, one at a time:
- The slot just after a load or branch, where a countdown that is one short would let the thread issue in its third shadow cycle.
- A single enabled thread that is always long, which must give three idle slots and then resume. A design that moved the pointer on idle cycles, or reported idle while a thread was ready, would show up here.
- A miss and a fill for the same thread in the same cycle; a fill-first priority would release the thread at once.
- A stray fill for a thread with no pending miss.
- A miss that lands inside a shadow.
- A parked thread, which must never appear in the rotation.

A cycle-accurate model checks every cycle in all of these cases. A picker that started from the last issuer instead of the one after it would repeat that thread and break the strict rotation.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
    typedef enum logic [1:0] {
        TS_PARKED = 2'd0,
        TS_READY  = 2'd1,
        TS_SHADOW = 2'd2,
        TS_MISS   = 2'd3
    } thr_state_t;
endpackage

// File: rtl/tsel_thread.sv
module tsel_thread
    import tsel_pkg::*;
#(
    parameter int SHADOW = 3,
    localparam int CNT_W = $clog2(SHADOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic grant,
    input  logic grant_long,
    input  logic miss_hit,
    input  logic fill_hit,
    output logic ready
);
    thr_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pend, pend_n;

    // Next values of the hold trackers; a new miss outranks a fill.
    always_comb begin
        if (miss_hit)
            pend_n = 1'b1;
        else if (fill_hit)
            pend_n = 1'b0;
        else
            pend_n = pend;

        if (grant && grant_long)
            cnt_n = CNT_W'(SHADOW);
        else if (cnt != '0)
            cnt_n = cnt - 1'b1;
        else
            cnt_n = '0;

        if (pend_n)
            state_n = TS_MISS;
        else if (cnt_n != '0)
            state_n = TS_SHADOW;
        else if (enable)
            state_n = TS_READY;
        else
            state_n = TS_PARKED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_PARKED;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pend  <= pend_n;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state)
            TS_READY:  ready = 1'b1;
            TS_PARKED: ready = 1'b0;
            TS_SHADOW: ready = 1'b0;
            TS_MISS:   ready = 1'b0;
            default:   ready = 1'b0;
        endcase
    end

    AST_MISS_NO_GRANT:   assert property (@(posedge clk) disable iff (!rst_n) pend |-> !grant); // R3
    AST_SHADOW_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (cnt != '0) |-> !grant); // R4
    AST_SHADOW_ENTRY:    assert property (@(posedge clk) disable iff (!rst_n) (grant && grant_long) |=> (state == TS_SHADOW || state == TS_MISS)); // R4
    AST_PARKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (state == TS_PARKED) |-> !grant); // R6
    AST_MISS_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n) (miss_hit && fill_hit) |=> (state == TS_MISS)); // R8
endmodule

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
    parameter int N = 4,
    localparam int TID_W = $clog2(N)
) (
    input  logic [N-1:0]     ready_vec,
    input  logic [TID_W-1:0] ptr,
    output logic             any,
    output logic [TID_W-1:0] pick
);
    // First ready thread at or after ptr, wrapping.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (!any && ready_vec[(int'(ptr) + i) % N]) begin
                any  = 1'b1;
                pick = TID_W'((int'(ptr) + i) % N);
            end
        end
    end
endmodule

// File: rtl/thread_select_top.sv
module thread_select_top #(
    parameter int NUM_THR = 4,
    parameter int SHADOW  = 3,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] thr_en,
    input  logic               issue_long,
    input  logic               miss_req,
    input  logic [TID_W-1:0]   miss_tid,
    input  logic               fill_req,
    input  logic [TID_W-1:0]   fill_tid,
    output logic               issue_valid,
    output logic [TID_W-1:0]   issue_tid
);
    logic [NUM_THR-1:0] rdy_vec;
    logic [NUM_THR-1:0] grant_vec;
    logic [TID_W-1:0]   ptr, ptr_n;
    logic               any;
    logic [TID_W-1:0]   pick;

    tsel_rr_pick #(.N(NUM_THR)) u_pick (
        .ready_vec (rdy_vec),
        .ptr       (ptr),
        .any       (any),
        .pick      (pick)
    );

    for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
        assign grant_vec[k] = any && (pick == TID_W'(k));
        tsel_thread #(.SHADOW(SHADOW)) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (thr_en[k]),
            .grant      (grant_vec[k]),
            .grant_long (issue_long),
            .miss_hit   (miss_req && (miss_tid == TID_W'(k))),
            .fill_hit   (fill_req && (fill_tid == TID_W'(k))),
            .ready      (rdy_vec[k])
        );
    end

    // Rotation pointer: one past the last issuer, held on idle slots.
    always_comb begin
        if (any)
            ptr_n = (pick == TID_W'(NUM_THR - 1)) ? '0 : pick + 1'b1;
        else
            ptr_n = ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else
            ptr <= ptr_n;
    end

    assign issue_valid = any;
    assign issue_tid   = pick;

    AST_ISSUE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> rdy_vec[issue_tid]); // R1
    AST_SWITCH_THREAD:  assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_valid) && ((rdy_vec & ~(NUM_THR'(1) << $past(issue_tid))) != '0)) |-> (issue_valid && issue_tid != $past(issue_tid))); // R2
    AST_IDLE_ALL_STALL: assert property (@(posedge clk) disable iff (!rst_n) !issue_valid |-> (rdy_vec == '0)); // R5
    AST_IDLE_PTR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !issue_valid |=> $stable(ptr)); // R5
    AST_ONE_GRANT:      assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_vec)); // R1
endmodule

// File: tb/thread_select_top_test.sv
module thread_select_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] thr_en = 4'b0;
    logic       issue_long = 1'b0;
    logic       miss_req = 1'b0;
    logic [1:0] miss_tid = 2'd0;
    logic       fill_req = 1'b0;
    logic [1:0] fill_tid = 2'd0;
    logic       issue_valid;
    logic [1:0] issue_tid;

    thread_select_top uut (
        .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .issue_long(issue_long),
        .miss_req(miss_req), .miss_tid(miss_tid), .fill_req(fill_req),
        .fill_tid(fill_tid), .issue_valid(issue_valid), .issue_tid(issue_tid)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cyc = 0;
    logic [3:0] long_mask = 4'b0;

    // Reference state, written from the requirements.
    logic [3:0] m_en = 4'b0;
    logic [3:0] m_pend = 4'b0;
    int         m_cnt [4] = '{0, 0, 0, 0};
    int         m_ptr = 0;
    int         last_long [4] = '{-100, -100, -100, -100};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: compare with model, respond with issue_long, advance.
    task automatic step(input string tag);
        bit exp_v = 1'b0;
        int exp_t = 0;
        for (int i = 0; i < 4; i++) begin
            int k = (m_ptr + i) % 4;
            if (!exp_v && m_en[k] && !m_pend[k] && m_cnt[k] == 0) begin
                exp_v = 1'b1;
                exp_t = k;
            end
        end
        check(issue_valid === exp_v, {tag, " valid"}, int'(issue_valid), int'(exp_v));
        if (exp_v)
            check(issue_tid === 2'(exp_t), {tag, " tid"}, int'(issue_tid), exp_t);
        if (issue_valid)
            check(cyc - last_long[issue_tid] > 3, "R4 shadow", cyc - last_long[issue_tid], 4);
        issue_long = issue_valid && long_mask[issue_tid];
        for (int k = 0; k < 4; k++) begin
            if (miss_req && miss_tid == 2'(k)) m_pend[k] = 1'b1;
            else if (fill_req && fill_tid == 2'(k)) m_pend[k] = 1'b0;
            if (exp_v && exp_t == k && long_mask[k]) m_cnt[k] = 3;
            else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
        end
        if (issue_long) last_long[issue_tid] = cyc;
        if (exp_v) m_ptr = (exp_t + 1) % 4;
        m_en = thr_en;
        @(posedge clk);
        #1;
        cyc++;
        miss_req = 1'b0;
        fill_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(issue_valid === 1'b0, "R7 reset idle", int'(issue_valid), 0);
        step("R7 parked");
        step("R7 parked");
    endtask

    task automatic t_rotate();
        thr_en = 4'b1111;
        long_mask = 4'b0000;
        step("R6 enable latency");
        check(issue_valid === 1'b1 && issue_tid === 2'd0, "R7 first thread", int'(issue_tid), 0);
        for (int n = 0; n < 8; n++) begin
            check(issue_tid === 2'(n % 4), "R1 rotation order", int'(issue_tid), n % 4);
            step("R2 switch");
        end
    endtask

    task automatic t_shadow();
        long_mask = 4'b0001;
        for (int n = 0; n < 12; n++) step("R4 shadow mix");
        long_mask = 4'b1111;
        for (int n = 0; n < 12; n++) step("R4 all long");
        long_mask = 4'b0000;
        for (int n = 0; n < 4; n++) step("R4 drain");
    endtask

    task automatic t_idle();
        thr_en = 4'b0010;
        long_mask = 4'b0010;
        for (int n = 0; n < 6; n++) step("R5 drain");
        for (int n = 0; n < 8; n++) begin
            if (!issue_valid) check(1'b1, "R5 idle seen", 0, 0);
            step("R5 single long thread");
        end
        long_mask = 4'b0000;
        thr_en = 4'b1111;
        for (int n = 0; n < 4; n++) step("R5 resume");
    endtask

    task automatic t_miss();
        miss_req = 1'b1; miss_tid = 2'd2;
        step("R3 miss report");
        for (int n = 0; n < 6; n++) begin
            check(!(issue_valid && issue_tid == 2'd2), "R3 blocked", int'(issue_tid), -1);
            step("R3 while pending");
        end
        fill_req = 1'b1; fill_tid = 2'd2;
        step("R3 fill");
        for (int n = 0; n < 4; n++) step("R3 after fill");
        miss_req = 1'b1; miss_tid = 2'd1;
        fill_req = 1'b1; fill_tid = 2'd1;
        step("R8 same cycle");
        for (int n = 0; n < 5; n++) begin
            check(!(issue_valid && issue_tid == 2'd1), "R8 still pending", int'(issue_tid), -1);
            step("R8 pending");
        end
        fill_req = 1'b1; fill_tid = 2'd1;
        step("R8 release");
        fill_req = 1'b1; fill_tid = 2'd3;
        step("R9 stray fill");
        for (int n = 0; n < 4; n++) step("R9 no effect");
    endtask

    task automatic t_miss_in_shadow();
        thr_en = 4'b0001;
        long_mask = 4'b0001;
        for (int n = 0; n < 5; n++) step("R10 setup");
        while (!issue_valid) step("R10 wait issue");
        step("R10 long issue");
        miss_req = 1'b1; miss_tid = 2'd0;
        step("R10 miss in shadow");
        for (int n = 0; n < 6; n++) begin
            check(issue_valid === 1'b0, "R10 blocked past shadow", int'(issue_valid), 0);
            step("R10 pending");
        end
        long_mask = 4'b0000;
        fill_req = 1'b1; fill_tid = 2'd0;
        step("R10 fill");
        check(issue_valid === 1'b1 && issue_tid === 2'd0, "R10 resumes", int'(issue_tid), 0);
        step("R10 run");
    endtask

    task automatic t_park();
        thr_en = 4'b0111;
        step("R6 park");
        for (int n = 0; n < 8; n++) begin
            check(!(issue_valid && issue_tid == 2'd3), "R6 parked never issues", int'(issue_tid), -1);
            step("R6 parked");
        end
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_shadow();
        t_idle();
        t_miss();
        t_miss_in_shadow();
        t_park();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule